// File: doc/BRIEF.md
# Multicore Private Region Register Decoder

This block decodes accesses into a 4 KB private peripheral window shared by up to four cores. The lowest page holds a small set of snoop-control registers that the block implements itself: a read/write control word, a read-only configuration word derived from the core-count parameter, a status word that reads as zero and an invalidate-all trigger. The pages above carry per-core CPU-interface and timer registers. The block does not implement these registers. It emits a select, a core or timer index and a sub-offset to the logic that owns them, and it returns that logic's read data on the bus.

Each CPU-interface and timer bank can be reached two ways. One page is an alias that routes to the requesting core, identified by a 2-bit sideband ID sent with each access. The other pages, at a 0x100 stride, address one specific core each. Targets at or above the configured core count are absent: reads from them return zero and writes to them are dropped. Offsets that decode to nothing raise an error response. The interrupt distributor sits in a separate 4 KB window directly above this region and is not decoded here.

A state machine sequences each access through three named states. `IDLE` accepts a request. `ISSUE` drives the downstream selects and captures the read data. `RESP` presents the response for one cycle. The transitions are: `IDLE` to `ISSUE` on an accepted request, `ISSUE` to `RESP` always, and `RESP` to `IDLE` always. All offsets below are byte offsets within the region, `acc_addr[11:0]`.

Top module: `priv_region_decode`

## Requirements
- R1: After reset `acc_ready` is 1, `rsp_valid`, `ci_sel`, `tm_sel` and `inv_strobe` are 0, and the control word at offset 0x00 reads 0.
- R2: A request is accepted on a clock edge where `acc_valid` and `acc_ready` are both 1. In the next cycle (ISSUE) at most one of `ci_sel`, `tm_sel` and `inv_strobe` is 1, and `acc_ready` is 0. In the cycle after that (RESP) `rsp_valid` is 1 for exactly one cycle. `acc_ready` returns to 1 in the cycle after RESP. For write accesses, `rsp_rdata` is 0 and `fwd_wdata` carries the write data during ISSUE.
- R3: Offset 0x00 is a 32-bit read/write control word. A read returns the last value written.
- R4: Offset 0x04 reads (((1<<NUM_CORES)-1)<<4) | (NUM_CORES-1), and writes to it have no effect. Offset 0x08 reads 0.
- R5: A write to offset 0x0C pulses `inv_strobe` for the ISSUE cycle, with the write data on `fwd_wdata`. A read of 0x0C returns 0 and does not pulse the strobe.
- R6: Offsets 0x100–0x1FF select the CPU interface of the requesting core: `ci_sel`=1, `ci_core`=`acc_core`, `ci_off`=offset[7:0]. A read returns `ci_rdata`.
- R7: Offsets 0x200–0x5FF select the CPU interface of core (offset-0x200)>>8, with `ci_off`=offset[7:0].
- R8: Offsets 0x600–0xAFF whose bits [7:6] are 0 are timer accesses. The core is the requester for 0x600–0x6FF and (offset-0x700)>>8 from 0x700 upward. `tm_idx` = core*2 + offset[5] and `tm_off` = offset[3:0]. A read returns `tm_rdata`.
- R9: An access whose target core is at or above NUM_CORES asserts no select, reads 0 and raises no error.
- R10: Offsets 0x10–0xFF, timer pages with offset[7:6] not 0, and offsets 0xB00–0xFFF give `rsp_err`=1 and `rsp_rdata`=0. Writes to them assert no select and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Request valid |
| acc_ready | output | 1 | Block can accept a request (IDLE) |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 12 | Byte offset within the region |
| acc_wdata | input | 32 | Write data |
| acc_core | input | 2 | ID of the requesting core |
| rsp_valid | output | 1 | Response valid (RESP) |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Undecoded offset |
| ci_sel | output | 1 | CPU-interface access strobe |
| ci_wr | output | 1 | CPU-interface access is a write |
| ci_core | output | 2 | Target core of the CPU-interface access |
| ci_off | output | 8 | CPU-interface register offset |
| ci_rdata | input | 32 | CPU-interface read data |
| tm_sel | output | 1 | Timer access strobe |
| tm_wr | output | 1 | Timer access is a write |
| tm_idx | output | 3 | Timer index |
| tm_off | output | 4 | Timer register offset |
| tm_rdata | input | 32 | Timer read data |
| inv_strobe | output | 1 | Invalidate-all pulse |
| fwd_wdata | output | 32 | Write data forwarded during ISSUE |

## Verification
The absent-core rule is the hardest case to reach from the ports. At the default of four cores every index is present, so the bench instantiates the block with three cores. Core 3 is then absent through both routes: through the explicit per-core pages, and through the alias pages with a sideband ID of 3. The bench also probes the timer-page holes where offset bits [7:6] are set, and it writes to undecoded offsets and to the configuration word before reading the control word back to show that no state changed.

// File: rtl/priv_region_pkg.sv
package priv_region_pkg;

    typedef enum logic [2:0] {
        RG_CTRL,
        RG_CONFIG,
        RG_STATUS,
        RG_INVAL,
        RG_CPUIF,
        RG_TIMER,
        RG_NONE
    } region_e;

    typedef struct packed {
        region_e    region;
        logic [1:0] core;
        logic       present;
    } dec_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ISSUE,
        S_RESP
    } state_e;

endpackage

// File: rtl/priv_addr_decode.sv
module priv_addr_decode
    import priv_region_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic [11:0] addr,
    input  logic [1:0]  req_core,
    output dec_t        dec
);

    localparam logic [11:0] CI_ALIAS_LO = 12'h100;
    localparam logic [11:0] CI_BANK_LO  = 12'h200;
    localparam logic [11:0] TM_ALIAS_LO = 12'h600;
    localparam logic [11:0] TM_BANK_LO  = 12'h700;
    localparam logic [11:0] TM_END      = 12'hB00;

    always_comb begin
        dec.region  = RG_NONE;
        dec.core    = req_core;
        if (addr < CI_ALIAS_LO) begin
            unique case (addr[7:0])
                8'h00:   dec.region = RG_CTRL;
                8'h04:   dec.region = RG_CONFIG;
                8'h08:   dec.region = RG_STATUS;
                8'h0C:   dec.region = RG_INVAL;
                default: dec.region = RG_NONE;
            endcase
        end else if (addr < TM_ALIAS_LO) begin
            dec.region = RG_CPUIF;
            if (addr >= CI_BANK_LO) begin
                // page minus 2, modulo 4
                dec.core = addr[9:8] - 2'd2;
            end
        end else if (addr < TM_END) begin
            if (addr[7:6] == 2'b00) begin
                dec.region = RG_TIMER;
            end
            if (addr >= TM_BANK_LO) begin
                // page minus 7, modulo 4
                dec.core = addr[9:8] - 2'd3;
            end
        end
        dec.present = (32'(dec.core) < NUM_CORES);
    end

endmodule

// File: rtl/priv_scu_regs.sv
module priv_scu_regs
    import priv_region_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [DATA_W-1:0] wdata,
    input  region_e           region,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [DATA_W-1:0] CORE_MASK = DATA_W'((1 << NUM_CORES) - 1);
    localparam logic [DATA_W-1:0] CFG_WORD  = (CORE_MASK << 4) | DATA_W'(NUM_CORES - 1);

    logic [DATA_W-1:0] ctrl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q <= wdata;
        end
    end

    always_comb begin
        unique case (region)
            RG_CTRL:   rdata = ctrl_q;
            RG_CONFIG: rdata = CFG_WORD;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/priv_region_decode.sv
module priv_region_decode
    import priv_region_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_valid,
    output logic        acc_ready,
    input  logic        acc_write,
    input  logic [11:0] acc_addr,
    input  logic [31:0] acc_wdata,
    input  logic [1:0]  acc_core,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        rsp_err,
    output logic        ci_sel,
    output logic        ci_wr,
    output logic [1:0]  ci_core,
    output logic [7:0]  ci_off,
    input  logic [31:0] ci_rdata,
    output logic        tm_sel,
    output logic        tm_wr,
    output logic [2:0]  tm_idx,
    output logic [3:0]  tm_off,
    input  logic [31:0] tm_rdata,
    output logic        inv_strobe,
    output logic [31:0] fwd_wdata
);

    state_e      state, state_nx;
    logic        q_wr;
    logic [11:0] q_addr;
    logic [31:0] q_wdata;
    logic [1:0]  q_core;
    logic [31:0] rdata_q, rdata_nx;
    logic        err_q, err_nx;
    dec_t        dec;
    logic [31:0] scu_rdata;
    logic        ctrl_we;
    logic        accept;

    priv_addr_decode #(.NUM_CORES(NUM_CORES)) u_dec (
        .addr     (q_addr),
        .req_core (q_core),
        .dec      (dec)
    );

    priv_scu_regs #(.NUM_CORES(NUM_CORES), .DATA_W(32)) u_scu (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_we (ctrl_we),
        .wdata   (q_wdata),
        .region  (dec.region),
        .rdata   (scu_rdata)
    );

    assign accept = acc_valid && (state == S_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (accept) state_nx = S_ISSUE;
            S_ISSUE: state_nx = S_RESP;
            S_RESP:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // request capture and response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_wr    <= 1'b0;
            q_addr  <= '0;
            q_wdata <= '0;
            q_core  <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            if (accept) begin
                q_wr    <= acc_write;
                q_addr  <= acc_addr;
                q_wdata <= acc_wdata;
                q_core  <= acc_core;
            end
            if (state == S_ISSUE) begin
                rdata_q <= rdata_nx;
                err_q   <= err_nx;
            end
        end
    end

    // read data and error selection for the ISSUE cycle
    always_comb begin
        rdata_nx = '0;
        err_nx   = 1'b0;
        unique case (dec.region)
            RG_CTRL, RG_CONFIG, RG_STATUS, RG_INVAL: rdata_nx = scu_rdata;
            RG_CPUIF: if (dec.present) rdata_nx = ci_rdata;
            RG_TIMER: if (dec.present) rdata_nx = tm_rdata;
            default:  err_nx = 1'b1;
        endcase
        if (q_wr) begin
            rdata_nx = '0;
        end
    end

    // outputs
    always_comb begin
        acc_ready  = 1'b0;
        rsp_valid  = 1'b0;
        ci_sel     = 1'b0;
        tm_sel     = 1'b0;
        inv_strobe = 1'b0;
        ctrl_we    = 1'b0;
        unique case (state)
            S_IDLE:  acc_ready = 1'b1;
            S_ISSUE: begin
                ci_sel     = (dec.region == RG_CPUIF) && dec.present;
                tm_sel     = (dec.region == RG_TIMER) && dec.present;
                inv_strobe = (dec.region == RG_INVAL) && q_wr;
                ctrl_we    = (dec.region == RG_CTRL) && q_wr;
            end
            S_RESP:  rsp_valid = 1'b1;
            default: acc_ready = 1'b0;
        endcase
    end

    assign ci_wr     = q_wr;
    assign tm_wr     = q_wr;
    assign ci_core   = dec.core;
    assign ci_off    = q_addr[7:0];
    assign tm_idx    = {dec.core, q_addr[5]};
    assign tm_off    = q_addr[3:0];
    assign fwd_wdata = q_wdata;
    assign rsp_rdata = rsp_valid ? rdata_q : '0;
    assign rsp_err   = rsp_valid & err_q;

endmodule

// File: rtl/priv_region_checker.sv
module priv_region_checker #(
    parameter int NUM_CORES = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic        acc_ready,
    input logic        rsp_valid,
    input logic [31:0] rsp_rdata,
    input logic        rsp_err,
    input logic        ci_sel,
    input logic [1:0]  ci_core,
    input logic        tm_sel,
    input logic [2:0]  tm_idx,
    input logic        inv_strobe
);

    assert_one_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ci_sel, tm_sel, inv_strobe}));

    assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ready) |=> !acc_ready);

    assert_select_then_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ci_sel || tm_sel || inv_strobe) |=> rsp_valid);

    assert_resp_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_err_zero_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_rdata == 32'd0));

    assert_ci_present_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ci_sel |-> (32'(ci_core) < NUM_CORES));

    assert_tm_present_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tm_sel |-> (32'(tm_idx[2:1]) < NUM_CORES));

endmodule

bind priv_region_decode priv_region_checker #(.NUM_CORES(NUM_CORES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_ready  (acc_ready),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .rsp_err    (rsp_err),
    .ci_sel     (ci_sel),
    .ci_core    (ci_core),
    .tm_sel     (tm_sel),
    .tm_idx     (tm_idx),
    .inv_strobe (inv_strobe)
);

// File: tb/tb_priv_region_decode.sv
`timescale 1ns/1ps
module tb_priv_region_decode;

    localparam int N = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_ready;
    logic        acc_write = 1'b0;
    logic [11:0] acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic [1:0]  acc_core = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic        ci_sel, ci_wr, tm_sel, tm_wr, inv_strobe;
    logic [1:0]  ci_core;
    logic [7:0]  ci_off;
    logic [2:0]  tm_idx;
    logic [3:0]  tm_off;
    logic [31:0] ci_rdata, tm_rdata, fwd_wdata;

    int checks = 0;
    int errors = 0;
    int m_ctrl = 0;

    int e_ci, e_tm, e_inv, e_err, e_core, e_off, e_tidx, e_toff;
    int e_rd;

    always #5 clk = ~clk;

    // downstream stubs: read data encodes the select fields
    assign ci_rdata = {8'hC1, 14'd0, ci_core, ci_off};
    assign tm_rdata = {8'h7E, 17'd0, tm_idx, tm_off};

    priv_region_decode #(.NUM_CORES(N)) dut (.*);

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // behavioural reference for one access
    task automatic model(input bit wr, input int a, input int c);
        int tc;
        e_ci = 0; e_tm = 0; e_inv = 0; e_err = 0; e_rd = 0;
        e_core = 0; e_off = 0; e_tidx = 0; e_toff = 0;
        if (a < 'h100) begin
            if (a == 0) e_rd = m_ctrl;
            else if (a == 4) e_rd = ((((1 << N) - 1)) << 4) | (N - 1);
            else if (a == 8) e_rd = 0;
            else if (a == 'hC) e_inv = wr;
            else e_err = 1;
        end else if (a < 'h600) begin
            tc = (a < 'h200) ? c : (a - 'h200) / 256;
            if (tc < N) begin
                e_ci = 1; e_core = tc; e_off = a % 256;
                e_rd = 'hC1000000 + tc * 256 + a % 256;
            end
        end else if (a < 'hB00) begin
            if ((a % 256) >= 64) e_err = 1;
            else begin
                tc = (a < 'h700) ? c : (a - 'h700) / 256;
                if (tc < N) begin
                    e_tm = 1; e_tidx = tc * 2 + (a / 32) % 2; e_toff = a % 16;
                    e_rd = 'h7E000000 + e_tidx * 16 + e_toff;
                end
            end
        end else e_err = 1;
        if (wr) e_rd = 0;
    endtask

    task automatic access(input string req, input bit wr, input int a, input int d, input int c);
        model(wr, a, c);
        @(negedge clk);
        chk(req, "ready idle", int'(acc_ready), 1);
        acc_valid = 1'b1; acc_write = wr; acc_addr = 12'(a); acc_wdata = d; acc_core = 2'(c);
        @(posedge clk);
        @(negedge clk);
        acc_valid = 1'b0;
        chk(req, "ready busy", int'(acc_ready), 0);
        chk(req, "ci_sel", int'(ci_sel), e_ci);
        chk(req, "tm_sel", int'(tm_sel), e_tm);
        chk(req, "inv_strobe", int'(inv_strobe), e_inv);
        if (e_ci) begin
            chk(req, "ci_core", int'(ci_core), e_core);
            chk(req, "ci_off", int'(ci_off), e_off);
            chk(req, "ci_wr", int'(ci_wr), int'(wr));
        end
        if (e_tm) begin
            chk(req, "tm_idx", int'(tm_idx), e_tidx);
            chk(req, "tm_off", int'(tm_off), e_toff);
            chk(req, "tm_wr", int'(tm_wr), int'(wr));
        end
        if (wr) chk(req, "fwd_wdata", fwd_wdata, d);
        chk(req, "rsp_valid early", int'(rsp_valid), 0);
        @(posedge clk);
        @(negedge clk);
        chk(req, "rsp_valid", int'(rsp_valid), 1);
        chk(req, "rsp_rdata", rsp_rdata, e_rd);
        chk(req, "rsp_err", int'(rsp_err), e_err);
        chk(req, "ci_sel resp", int'(ci_sel | tm_sel | inv_strobe), 0);
        if (wr && a == 0) m_ctrl = d;
        @(posedge clk);
        @(negedge clk);
        chk(req, "rsp_valid drop", int'(rsp_valid), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1", "ready", int'(acc_ready), 1);
        chk("R1", "rsp_valid", int'(rsp_valid), 0);
        chk("R1", "selects", int'(ci_sel | tm_sel | inv_strobe), 0);
        access("R1", 0, 'h000, 0, 0);
        // R3 control word
        access("R3", 1, 'h000, 'hA5A51234, 1);
        access("R3", 0, 'h000, 0, 2);
        // R4 configuration and status
        access("R4", 1, 'h004, 'hFFFF, 0);
        access("R4", 0, 'h004, 0, 0);
        access("R4", 0, 'h008, 0, 1);
        access("R4", 0, 'h000, 0, 0);
        // R5 invalidate-all
        access("R5", 1, 'h00C, 'h0000BEEF, 0);
        access("R5", 0, 'h00C, 0, 0);
        // R6 alias CPU interface
        access("R6", 0, 'h104, 0, 2);
        access("R6", 1, 'h1F0, 'h55, 1);
        // R7 explicit CPU interface
        access("R7", 0, 'h3A8, 0, 0);
        access("R7", 1, 'h404, 'h77, 0);
        access("R7", 0, 'h200, 0, 2);
        // R8 timers
        access("R8", 0, 'h624, 0, 1);
        access("R8", 1, 'h60C, 'h99, 2);
        access("R8", 0, 'h90C, 0, 0);
        access("R8", 0, 'h738, 0, 2);
        // R9 absent core 3
        access("R9", 0, 'h5FC, 0, 0);
        access("R9", 1, 'h500, 'h11, 0);
        access("R9", 0, 'h120, 0, 3);
        access("R9", 0, 'h620, 0, 3);
        access("R9", 1, 'hA20, 'h22, 0);
        // R10 undecoded offsets
        access("R10", 0, 'h010, 0, 0);
        access("R10", 1, 'h010, 'hDEAD, 0);
        access("R10", 0, 'h680, 0, 0);
        access("R10", 1, 'h7C0, 'h33, 0);
        access("R10", 0, 'hB00, 0, 0);
        access("R10", 0, 'hFFC, 0, 1);
        access("R10", 0, 'h000, 0, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule